// File: doc/BRIEF.md
# Inline Packet Header Field Extractor

This block sits inside a wide packet stream, 128 bits per beat with byte 0 of each packet on the lowest byte lane. Every packet is assumed to begin with an Ethernet header, an option-free IPv4 header and a UDP header, followed by a tunnel header.

While the first beats of a packet flow through, the block picks out a set of header fields:

- the IPv4 source and destination addresses
- the IP protocol number
- the two UDP ports
- the tunnel message type

It presents these as sideband metadata next to the same packet. Data, keep, last and valid pass through unchanged in the same cycle, and ready passes straight back. The block therefore adds no latency and holds no storage on the data path.

Network-order fields are built most significant byte first. The tunnel type word is read least significant byte first. The destination address straddles a beat boundary, so the bytes that arrive in earlier beats are held in small per-byte taps. The metadata becomes valid on the beat that carries the last header byte it needs, and it stays constant until that packet's final beat. A downstream lookup stage can use the metadata in the same cycle as the third beat.

Top module: `hx_header_extract`

## Requirements
- R1: `m_tdata`, `m_tkeep`, `m_tlast` and `m_tvalid` equal `s_tdata`, `s_tkeep`, `s_tlast` and `s_tvalid` in every cycle, and `s_tready` equals `m_tready`.
- R2: A beat counts as accepted only when valid and ready are both high. The first beat after reset, and the first beat after an accepted `tlast` beat, is beat 0 of a new packet.
- R3: `m_meta_valid` is high while valid is high on beat 2 or any later beat of a packet. It is low on beats 0 and 1.
- R4: `m_src_ip` is packet bytes 26..29 and `m_dst_ip` is packet bytes 30..33, each with the lower byte address as the most significant byte. The destination spans beats 1 and 2.
- R5: `m_src_port` is bytes 34..35 and `m_dst_port` is bytes 36..37, each with the lower byte address as the most significant byte.
- R6: `m_ip_proto` is byte 23. `m_is_udp` is 1 exactly when that byte equals 17.
- R7: The tunnel type word is bytes 42..45 with byte 42 least significant. When the packet is UDP and the word is 1, 2, 3 or 4, `m_msg_type` reports it. Those codes mean handshake initiation, handshake response, cookie reply and transport data. Any other word, or a non-UDP packet, gives 0.
- R8: `m_runt` is high on the `tlast` beat of a packet that ends on beat 0 or beat 1. On that beat `m_meta_valid` is low.
- R9: From beat 2 through the `tlast` beat, the metadata stays constant across stalls, whether ready or valid is low.
- R10: While reset is active, and after a reset that cuts a packet short, the next presented beat is treated as beat 0: `m_meta_valid` and `m_runt` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 128 | Incoming packet data, byte 0 in bits 7:0 |
| s_tkeep | input | 16 | Incoming byte enables |
| s_tvalid | input | 1 | Incoming beat valid |
| s_tlast | input | 1 | Incoming last beat of packet |
| s_tready | output | 1 | Ready returned to the source |
| m_tdata | output | 128 | Forwarded packet data |
| m_tkeep | output | 16 | Forwarded byte enables |
| m_tvalid | output | 1 | Forwarded beat valid |
| m_tlast | output | 1 | Forwarded last beat |
| m_tready | input | 1 | Ready from the sink |
| m_meta_valid | output | 1 | Metadata fields are valid on this beat |
| m_src_ip | output | 32 | IPv4 source address |
| m_dst_ip | output | 32 | IPv4 destination address |
| m_src_port | output | 16 | UDP source port |
| m_dst_port | output | 16 | UDP destination port |
| m_ip_proto | output | 8 | IP protocol number |
| m_is_udp | output | 1 | Protocol number is 17 |
| m_msg_type | output | 3 | Tunnel message type code, 0 if none |
| m_runt | output | 1 | Packet ended before beat 2 |

## Verification
All four valid type words are sent, with packet lengths of exactly three beats and longer. These tell apart a metadata path that works only on the capture beat from one that also holds the registered copy on later beats.

Words 0x100 and 0x01000000 are sent, and so is a TCP packet carrying a valid type word. These catch swapped byte order in the tunnel word and a missing UDP qualification.

Distinct bytes at every header position expose a byte-reversal error in the addresses and ports, including the destination bytes that sit in the earlier beat.

One-beat and two-beat runts, and a reset in the middle of a packet, check the beat counter. Each scenario runs twice: once with ready held high and once with pseudo-random ready and valid gaps. The second run shows whether a stall disturbs the capture or the held metadata.

// File: rtl/hx_pkg.sv
package hx_pkg;

    typedef enum logic [2:0] {
        MSG_NONE   = 3'd0,
        MSG_INIT   = 3'd1,
        MSG_RESP   = 3'd2,
        MSG_COOKIE = 3'd3,
        MSG_DATA   = 3'd4
    } msg_kind_e;

    typedef struct packed {
        logic [31:0] src_ip;
        logic [31:0] dst_ip;
        logic [15:0] src_port;
        logic [15:0] dst_port;
        logic [7:0]  proto;
        logic        is_udp;
        msg_kind_e   kind;
    } hdr_meta_t;

    localparam logic [7:0] PROTO_UDP = 8'd17;

    // Gathered header bytes, kept in packet order within each field
    localparam int FB_PROTO   = 0;
    localparam int FB_SRC     = 1;
    localparam int FB_DST     = 5;
    localparam int FB_SPORT   = 9;
    localparam int FB_DPORT   = 11;
    localparam int FB_MSG     = 13;
    localparam int HDR_NBYTES = 17;

endpackage

// File: rtl/hx_beat_ctr.sv
module hx_beat_ctr #(
    parameter int LAST_BEAT = 2,
    localparam int CNT_W = $clog2(LAST_BEAT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             last,
    output logic [CNT_W-1:0] beat
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(LAST_BEAT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            if (last) begin
                cnt_d = '0;
            end else if (cnt_q != SAT) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign beat = cnt_q;
endmodule

// File: rtl/hx_byte_tap.sv
module hx_byte_tap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] d,
    output logic [7:0] q
);
    logic [7:0] tap_d, tap_q;

    always_comb begin
        tap_d = tap_q;
        if (load) begin
            tap_d = d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_d;
        end
    end

    assign q = tap_q;
endmodule

// File: rtl/hx_meta_fmt.sv
module hx_meta_fmt
    import hx_pkg::*;
(
    input  logic [HDR_NBYTES*8-1:0] hb,
    output hdr_meta_t               meta
);
    logic [31:0] type_word;

    function automatic logic [7:0] hbyte(input logic [HDR_NBYTES*8-1:0] v, input int idx);
        return v[8*idx +: 8];
    endfunction

    always_comb begin
        // Network order: the lower packet address is the more significant byte
        meta.proto    = hbyte(hb, FB_PROTO);
        meta.src_ip   = {hbyte(hb, FB_SRC), hbyte(hb, FB_SRC + 1),
                         hbyte(hb, FB_SRC + 2), hbyte(hb, FB_SRC + 3)};
        meta.dst_ip   = {hbyte(hb, FB_DST), hbyte(hb, FB_DST + 1),
                         hbyte(hb, FB_DST + 2), hbyte(hb, FB_DST + 3)};
        meta.src_port = {hbyte(hb, FB_SPORT), hbyte(hb, FB_SPORT + 1)};
        meta.dst_port = {hbyte(hb, FB_DPORT), hbyte(hb, FB_DPORT + 1)};
        // Tunnel header: the lower packet address is the less significant byte
        type_word     = {hbyte(hb, FB_MSG + 3), hbyte(hb, FB_MSG + 2),
                         hbyte(hb, FB_MSG + 1), hbyte(hb, FB_MSG)};
        meta.is_udp   = (meta.proto == PROTO_UDP);
        meta.kind     = MSG_NONE;
        if (meta.is_udp && (type_word >= 32'd1) && (type_word <= 32'd4)) begin
            meta.kind = msg_kind_e'(type_word[2:0]);
        end
    end
endmodule

// File: rtl/hx_header_extract.sv
module hx_header_extract
    import hx_pkg::*;
#(
    parameter int DATA_W        = 128,
    parameter int ETH_HDR_BYTES = 14,
    parameter int IP_HDR_BYTES  = 20,
    parameter int UDP_HDR_BYTES = 8,
    localparam int KEEP_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [KEEP_W-1:0] s_tkeep,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [KEEP_W-1:0] m_tkeep,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    output logic              m_meta_valid,
    output logic [31:0]       m_src_ip,
    output logic [31:0]       m_dst_ip,
    output logic [15:0]       m_src_port,
    output logic [15:0]       m_dst_port,
    output logic [7:0]        m_ip_proto,
    output logic              m_is_udp,
    output logic [2:0]        m_msg_type
    ,output logic             m_runt
);
    localparam int BEAT_BYTES = KEEP_W;
    localparam int OFF_PROTO  = ETH_HDR_BYTES + 9;
    localparam int OFF_SRC    = ETH_HDR_BYTES + 12;
    localparam int OFF_DST    = ETH_HDR_BYTES + 16;
    localparam int OFF_SPORT  = ETH_HDR_BYTES + IP_HDR_BYTES;
    localparam int OFF_DPORT  = OFF_SPORT + 2;
    localparam int OFF_MSG    = OFF_SPORT + UDP_HDR_BYTES;
    localparam int HDR_END    = OFF_MSG + 4;
    localparam int LAST_BEAT  = (HDR_END - 1) / BEAT_BYTES;
    localparam int CNT_W      = $clog2(LAST_BEAT + 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LAST_BEAT);

    // Packet offset of each gathered header byte
    function automatic int pkt_pos(input int j);
        if (j < FB_SRC)   return OFF_PROTO;
        if (j < FB_DST)   return OFF_SRC + j - FB_SRC;
        if (j < FB_SPORT) return OFF_DST + j - FB_DST;
        if (j < FB_DPORT) return OFF_SPORT + j - FB_SPORT;
        if (j < FB_MSG)   return OFF_DPORT + j - FB_DPORT;
        return OFF_MSG + j - FB_MSG;
    endfunction

    typedef struct packed {
        hdr_meta_t meta;
    } st_t;

    st_t                    st_d, st_q;
    logic                   acc;
    logic [CNT_W-1:0]       beat;
    logic [HDR_NBYTES*8-1:0] hb_live;
    hdr_meta_t              live_meta;
    hdr_meta_t              meta_out;

    assign acc = s_tvalid && m_tready;

    hx_beat_ctr #(.LAST_BEAT(LAST_BEAT)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (acc),
        .last    (s_tlast),
        .beat    (beat)
    );

    for (genvar j = 0; j < HDR_NBYTES; j++) begin : g_hb
        localparam int POS  = pkt_pos(j);
        localparam int PB   = POS / BEAT_BYTES;
        localparam int LANE = POS % BEAT_BYTES;
        if (PB < LAST_BEAT) begin : g_early
            logic [7:0] tap_q;
            hx_byte_tap u_tap (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (acc && (beat == CNT_W'(PB))),
                .d     (s_tdata[8*LANE +: 8]),
                .q     (tap_q)
            );
            assign hb_live[8*j +: 8] = tap_q;
        end else begin : g_live
            assign hb_live[8*j +: 8] = s_tdata[8*LANE +: 8];
        end
    end

    hx_meta_fmt u_fmt (
        .hb   (hb_live),
        .meta (live_meta)
    );

    always_comb begin
        st_d = st_q;
        if (acc && (beat == LAST_CNT)) begin
            st_d.meta = live_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign meta_out     = (beat == LAST_CNT) ? live_meta : st_q.meta;

    assign s_tready     = m_tready;
    assign m_tdata      = s_tdata;
    assign m_tkeep      = s_tkeep;
    assign m_tvalid     = s_tvalid;
    assign m_tlast      = s_tlast;

    assign m_meta_valid = s_tvalid && (beat >= LAST_CNT);
    assign m_runt       = s_tvalid && s_tlast && (beat < LAST_CNT);
    assign m_src_ip     = meta_out.src_ip;
    assign m_dst_ip     = meta_out.dst_ip;
    assign m_src_port   = meta_out.src_port;
    assign m_dst_port   = meta_out.dst_port;
    assign m_ip_proto   = meta_out.proto;
    assign m_is_udp     = meta_out.is_udp;
    assign m_msg_type   = meta_out.kind;
endmodule

// File: rtl/hx_header_extract_chk.sv
module hx_header_extract_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        m_tlast,
    input logic        m_meta_valid,
    input logic        m_runt,
    input logic [31:0] m_src_ip,
    input logic [31:0] m_dst_ip,
    input logic [15:0] m_src_port,
    input logic [15:0] m_dst_port,
    input logic [7:0]  m_ip_proto,
    input logic        m_is_udp,
    input logic [2:0]  m_msg_type
);
    // R8
    runt_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_runt |-> (m_tvalid && m_tlast && !m_meta_valid));

    // R2
    restart_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> !m_meta_valid);

    // R3
    meta_stays_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_meta_valid && !m_tlast) |=> (!m_tvalid || m_meta_valid));

    // R7
    type_needs_udp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_meta_valid && (m_msg_type != 3'd0)) |-> m_is_udp);

    // R9
    meta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_meta_valid && !(m_tready && m_tlast)) ##1 m_meta_valid |->
            ($stable(m_src_ip) && $stable(m_dst_ip) && $stable(m_src_port) &&
             $stable(m_dst_port) && $stable(m_ip_proto) && $stable(m_msg_type)));
endmodule

bind hx_header_extract hx_header_extract_chk u_chk (.*);

// File: tb/hx_header_extract_test.sv
module hx_header_extract_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] s_tdata;
    logic [15:0]  s_tkeep;
    logic         s_tvalid, s_tlast, s_tready;
    logic [127:0] m_tdata;
    logic [15:0]  m_tkeep;
    logic         m_tvalid, m_tlast, m_tready;
    logic         m_meta_valid, m_is_udp, m_runt;
    logic [31:0]  m_src_ip, m_dst_ip;
    logic [15:0]  m_src_port, m_dst_port;
    logic [7:0]   m_ip_proto;
    logic [2:0]   m_msg_type;

    always #4 clk = ~clk;

    hx_header_extract uut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
        .m_tready(m_tready),
        .m_meta_valid(m_meta_valid), .m_src_ip(m_src_ip), .m_dst_ip(m_dst_ip),
        .m_src_port(m_src_port), .m_dst_port(m_dst_port), .m_ip_proto(m_ip_proto),
        .m_is_udp(m_is_udp), .m_msg_type(m_msg_type), .m_runt(m_runt)
    );

    int           checks = 0;
    int           fails  = 0;
    bit           done = 0;
    bit           after_rst = 0;
    bit           rdy_rand = 0;
    logic [15:0]  lfsr = 16'hACE1;
    byte unsigned acc_q[$];
    byte unsigned pkt[0:127];

    task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: bytes accepted so far in the current packet
    int           beat;
    byte unsigned w[0:47];
    logic [31:0]  e_src, e_dst, e_word;
    logic [15:0]  e_sp, e_dp;
    logic [7:0]   e_proto;
    logic [2:0]   e_type;
    bit           e_mv, e_runt;

    always @(negedge clk) begin
        if (!rst_n) begin
            acc_q.delete();
        end else if (!done) begin
            beat   = acc_q.size() / 16;
            e_mv   = s_tvalid && (beat >= 2);
            e_runt = s_tvalid && s_tlast && (beat < 2);
            check("R1", "valid", m_tvalid, s_tvalid);
            check("R1", "ready", s_tready, m_tready);
            if (s_tvalid) begin
                check("R1", "data", m_tdata, s_tdata);
                check("R1", "keep", m_tkeep, s_tkeep);
                check("R1", "last", m_tlast, s_tlast);
            end
            check(after_rst ? "R10" : (beat == 0 ? "R2" : "R3"), "meta_valid", m_meta_valid, e_mv);
            check("R8", "runt", m_runt, e_runt);
            if (e_mv) begin
                for (int i = 0; i < 48; i++) begin
                    if (i < acc_q.size()) w[i] = acc_q[i];
                    else w[i] = s_tdata[8*(i-32) +: 8];
                end
                e_src   = {w[26], w[27], w[28], w[29]};
                e_dst   = {w[30], w[31], w[32], w[33]};
                e_sp    = {w[34], w[35]};
                e_dp    = {w[36], w[37]};
                e_proto = w[23];
                e_word  = {w[45], w[44], w[43], w[42]};
                e_type  = ((e_proto == 8'd17) && (e_word >= 1) && (e_word <= 4)) ? e_word[2:0] : 3'd0;
                check(m_tready ? "R4" : "R9", "src_ip", m_src_ip, e_src);
                check(m_tready ? "R4" : "R9", "dst_ip", m_dst_ip, e_dst);
                check(m_tready ? "R5" : "R9", "src_port", m_src_port, e_sp);
                check(m_tready ? "R5" : "R9", "dst_port", m_dst_port, e_dp);
                check("R6", "proto", m_ip_proto, e_proto);
                check("R6", "is_udp", m_is_udp, e_proto == 8'd17);
                check("R7", "msg_type", m_msg_type, e_type);
            end
            if (s_tvalid && m_tready) begin
                after_rst = 0;
                for (int i = 0; i < 16; i++) acc_q.push_back(s_tdata[8*i +: 8]);
                if (s_tlast) acc_q.delete();
            end
        end
    end

    initial begin
        m_tready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m_tready = rdy_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
        end
    end

    task automatic build(input logic [7:0] proto, input logic [31:0] src, input logic [31:0] dst,
                         input logic [15:0] sp, input logic [15:0] dp, input logic [31:0] word,
                         input int seed);
        for (int i = 0; i < 128; i++) pkt[i] = 8'(seed + 13 * i);
        pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[14] = 8'h45; pkt[23] = proto;
        for (int k = 0; k < 4; k++) begin
            pkt[26+k] = src[31-8*k -: 8];
            pkt[30+k] = dst[31-8*k -: 8];
            pkt[42+k] = word[8*k +: 8];
        end
        pkt[34] = sp[15:8]; pkt[35] = sp[7:0];
        pkt[36] = dp[15:8]; pkt[37] = dp[7:0];
    endtask

    task automatic send(input int nb, input int gap, input int cut);
        for (int b = 0; b < cut; b++) begin
            for (int i = 0; i < 16; i++) s_tdata[8*i +: 8] = pkt[16*b + i];
            s_tkeep  = (b == nb - 1) ? 16'h0FFF : 16'hFFFF;
            s_tlast  = (b == nb - 1);
            s_tvalid = 1'b1;
            forever begin
                @(posedge clk);
                if (m_tready) break;
            end
            #1;
            s_tvalid = 1'b0;
            s_tlast  = 1'b0;
            if (gap > 0 && (b % 2 == 0)) begin
                repeat (gap) @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic suite(input int gap);
        build(8'd17, 32'h0A0A0002, 32'h0A0A0001, 16'd51820, 16'd40000, 32'd1, 3);   send(4, gap, 4);
        build(8'd17, 32'hC0A80102, 32'h0A090002, 16'h1234, 16'h5678, 32'd2, 7);    send(3, gap, 3);
        build(8'd17, 32'h01020304, 32'h05060708, 16'hA1B2, 16'hC3D4, 32'd3, 11);   send(5, gap, 5);
        build(8'd17, 32'hFEDCBA98, 32'h76543210, 16'h0001, 16'hFFFE, 32'd4, 17);   send(6, gap, 6);
        build(8'd6,  32'h11223344, 32'h55667788, 16'h0050, 16'h1F90, 32'd1, 23);   send(4, gap, 4);
        build(8'd17, 32'h99AABBCC, 32'hDDEEFF00, 16'h0100, 16'h0200, 32'd5, 29);   send(3, gap, 3);
        build(8'd17, 32'h0A000001, 32'h0A000002, 16'h0303, 16'h0404, 32'h100, 31); send(4, gap, 4);
        build(8'd17, 32'h0A000003, 32'h0A000004, 16'h0505, 16'h0606, 32'h01000000, 37); send(3, gap, 3);
        build(8'd17, 32'h0B000001, 32'h0B000002, 16'h0707, 16'h0808, 32'd1, 41);   send(1, gap, 1);
        build(8'd17, 32'h0C000001, 32'h0C000002, 16'h0909, 16'h0A0A, 32'd2, 43);   send(2, gap, 2);
        build(8'd17, 32'h0D000001, 32'h0D000002, 16'h0B0B, 16'h0C0C, 32'd3, 47);   send(3, gap, 3);
    endtask

    initial begin
        rst_n = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0; s_tkeep = '0;
        repeat (2) @(posedge clk);
        #1;
        s_tvalid = 1'b1; s_tdata = {4{32'hDEADBEEF}}; s_tkeep = '1;
        @(negedge clk);
        check("R10", "meta_valid in reset", m_meta_valid, 1'b0);
        check("R10", "runt in reset", m_runt, 1'b0);
        @(posedge clk);
        #1;
        s_tvalid = 1'b0; rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        suite(0);
        rdy_rand = 1;
        suite(2);
        // reset cuts a packet after three beats
        build(8'd17, 32'h0E000001, 32'h0E000002, 16'h1111, 16'h2222, 32'd4, 53);
        send(5, 0, 3);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        after_rst = 1;
        build(8'd17, 32'h0F000001, 32'h0F000002, 16'h3333, 16'h4444, 32'd2, 59);
        send(4, 1, 4);
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule